// File: doc/BRIEF.md
# Multi-Queue Free Pointer Pool

This block is a hardware allocator for free buffers. It serves a fixed number of independent pools, eight by default. Each pool keeps the free buffer pointers it holds in one shared on-chip pointer store. Software gives each pool a region of that store by writing the region's size. The regions are placed back to back in pool order, so each region's start is the sum of the sizes of all lower-numbered pools. Inside its region, each pool works as a circular FIFO.

A producer returns a buffer by presenting a pointer and a pool number on the free port. A consumer takes a buffer by naming a pool on the alloc port. The pointer comes back on the next cycle, or zero when the pool has nothing to give. Each pool compares its occupancy with a programmable high watermark and a programmable low watermark. From these comparisons it raises a spill request (write pointers out) or a refill request (read pointers back in), which an external mover acts on. A per-pool available count can be read through a pool selector. When a region size is written, the layout changes: the block empties every pool and holds off traffic for a fixed settling time.

Top module: `free_ptr_pool`

## Requirements
- R1: After reset, `ready` is 1, every pool is empty, every available count is 0, and all `spill_req`, `refill_req` and `ovf_flag` bits are 0.
- R2: Bit 0 of a written region size is treated as 0. A region of size N holds at most N-2 pointers, and 0 pointers if N is below 2. A free to a pool that is at capacity is discarded and sets that pool's `ovf_flag` bit. The bit stays set until reset.
- R3: A size write drives `ready` low for exactly 10 cycles, starting with the cycle after the write, and empties every pool. A free or alloc presented while `ready` is low, or in the same cycle as a size write, is ignored, and the alloc returns 0.
- R4: Every `alloc_req` is answered one cycle later with `alloc_vld`=1. Each pool returns its pointers in the order they were freed into it.
- R5: An alloc from an empty pool returns 0.
- R6: Regions are laid out in pool order, with pool 0 at entry 0. Traffic to one pool never changes the pointers returned by another pool.
- R7: The read and write positions of each pool wrap inside its own region, so FIFO order holds over any number of passes.
- R8: An alloc and a free to the same pool in the same cycle are both serviced and the pool's count does not change. If the pool is empty, the alloc returns the pointer being freed.
- R9: `spill_req[q]` is 1 exactly when pool q holds more pointers than its high watermark.
- R10: `refill_req[q]` is 1 exactly when pool q holds fewer pointers than its low watermark and its available count is nonzero.
- R11: `avail_cnt` shows the number of pointers held by the pool that `avail_q` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size_wr | input | 1 | Write the region size of pool `cfg_q` |
| cfg_mark_wr | input | 1 | Write the watermarks of pool `cfg_q` |
| cfg_q | input | $clog2(NUM_Q) | Pool addressed by a configuration write |
| cfg_size | input | $clog2(DEPTH)+1 | Region size (bit 0 ignored) |
| cfg_hi | input | $clog2(DEPTH) | High watermark |
| cfg_lo | input | $clog2(DEPTH) | Low watermark |
| ready | output | 1 | 1 when free and alloc traffic is accepted |
| free_vld | input | 1 | Free request |
| free_q | input | $clog2(NUM_Q) | Pool for the free |
| free_ptr | input | PTR_W | Pointer being freed |
| alloc_req | input | 1 | Alloc request |
| alloc_q | input | $clog2(NUM_Q) | Pool for the alloc |
| alloc_vld | output | 1 | Alloc response valid, one cycle after the request |
| alloc_ptr | output | PTR_W | Allocated pointer, or 0 when none is available |
| spill_req | output | NUM_Q | Per-pool occupancy above the high watermark |
| refill_req | output | NUM_Q | Per-pool occupancy below the low watermark, with pointers held |
| ovf_flag | output | NUM_Q | Sticky per-pool dropped-free flag |
| avail_q | input | $clog2(NUM_Q) | Pool selected for readback |
| avail_cnt | output | AVAIL_W | Available count of the selected pool |

## Verification
The bench builds the block with NUM_Q=8, DEPTH=64, PTR_W=32 and the default 10-cycle settling time. The small store lets the programmed regions, of sizes 8, 4, 6 and 44 with an odd size written for pool 1, fill almost the whole storage. At that depth, a pool can be driven to capacity, and its read and write positions can be wrapped several times, in a few dozen cycles each. The 6-bit watermarks are set to small values, so the spill and refill thresholds are crossed with only a handful of frees.

// File: rtl/fpool_pkg.sv
// Package fpool_pkg
// Shared types for the free pointer pool. Holds the encoding of where an
// alloc response gets its data.
package fpool_pkg;

    typedef enum logic [1:0] {
        RSP_ZERO   = 2'd0,   // nothing serviced, answer zero
        RSP_RAM    = 2'd1,   // pointer read from the shared store
        RSP_BYPASS = 2'd2    // pointer forwarded from a same-cycle free
    } rsp_src_e;

endpackage

// File: rtl/fpool_cfg.sv
// Module fpool_cfg
// Holds the per-pool region sizes and watermarks. It derives each region's
// base as the running sum of the lower sizes, and each region's capacity
// as size-2. It also runs the settling counter that follows a size write.
// Assumes software keeps the sum of sizes within DEPTH.
module fpool_cfg #(
    parameter int NUM_Q      = 8,
    parameter int DEPTH      = 2048,
    parameter int SETTLE_CYC = 10,
    localparam int Q_W    = $clog2(NUM_Q),
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SIZE_W = ADDR_W + 1,
    localparam int WM_W   = ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         size_wr,
    input  logic                         mark_wr,
    input  logic [Q_W-1:0]               cfg_q,
    input  logic [SIZE_W-1:0]            cfg_size,
    input  logic [WM_W-1:0]              cfg_hi,
    input  logic [WM_W-1:0]              cfg_lo,
    output logic [NUM_Q-1:0][SIZE_W-1:0] size_o,
    output logic [NUM_Q-1:0][SIZE_W-1:0] base_o,
    output logic [NUM_Q-1:0][SIZE_W-1:0] cap_o,
    output logic [NUM_Q-1:0][WM_W-1:0]   hi_o,
    output logic [NUM_Q-1:0][WM_W-1:0]   lo_o,
    output logic                         ready_o
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0]  settle_cnt;
    logic [SIZE_W-1:0] run_sum;

    // Size and watermark registers; the size loses its bit 0 on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_o <= '0;
            hi_o   <= '1;
            lo_o   <= '0;
        end else begin
            if (size_wr)
                size_o[cfg_q] <= {cfg_size[SIZE_W-1:1], 1'b0};
            if (mark_wr) begin
                hi_o[cfg_q] <= cfg_hi;
                lo_o[cfg_q] <= cfg_lo;
            end
        end
    end

    // Settling counter: reloads on every size write, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle_cnt <= '0;
        else if (size_wr)
            settle_cnt <= CNT_W'(SETTLE_CYC);
        else if (settle_cnt != '0)
            settle_cnt <= settle_cnt - CNT_W'(1);
    end

    assign ready_o = (settle_cnt == '0);

    // Region bases: running sum of the sizes in pool order.
    always_comb begin
        run_sum = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            base_o[q] = run_sum;
            run_sum   = run_sum + size_o[q];
        end
    end

    // Usable capacity of each region is two less than its size.
    for (genvar g = 0; g < NUM_Q; g++) begin : g_cap
        assign cap_o[g] = (size_o[g] >= SIZE_W'(2)) ? size_o[g] - SIZE_W'(2) : '0;
    end

    AST_SETTLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        size_wr |=> !ready_o); // R3

endmodule

// File: rtl/fpool_qctl.sv
// Module fpool_qctl
// Bookkeeping for one pool. It keeps the read and write offsets inside the
// region (circular), the occupancy, the available count, the sticky
// overflow flag and the watermark requests. Assumes push and pop are
// already qualified by the top: push never arrives when full unless pop
// arrives with it, and pop never arrives when empty.
module fpool_qctl #(
    parameter int SIZE_W  = 12,
    parameter int AVAIL_W = 26,
    localparam int WM_W   = SIZE_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  logic               pop,
    input  logic               drop,
    input  logic [SIZE_W-1:0]  size,
    input  logic [SIZE_W-1:0]  cap,
    input  logic [WM_W-1:0]    hi,
    input  logic [WM_W-1:0]    lo,
    output logic [SIZE_W-1:0]  rd_off,
    output logic [SIZE_W-1:0]  wr_off,
    output logic [AVAIL_W-1:0] avail,
    output logic               empty,
    output logic               full,
    output logic               ovf,
    output logic               spill,
    output logic               refill
);

    logic [SIZE_W-1:0] occ;
    logic [SIZE_W-1:0] last_off;

    assign last_off = size - SIZE_W'(1);

    // Read and write offsets advance and wrap at the region end.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_off <= '0;
            wr_off <= '0;
        end else begin
            if (pop)
                rd_off <= (rd_off == last_off) ? '0 : rd_off + SIZE_W'(1);
            if (push)
                wr_off <= (wr_off == last_off) ? '0 : wr_off + SIZE_W'(1);
        end
    end

    // Occupancy and available count; push with pop leaves both unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            occ   <= '0;
            avail <= '0;
        end else if (push && !pop) begin
            occ   <= occ + SIZE_W'(1);
            avail <= avail + AVAIL_W'(1);
        end else if (pop && !push) begin
            occ   <= occ - SIZE_W'(1);
            avail <= avail - AVAIL_W'(1);
        end
    end

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
    end

    assign empty  = (occ == '0);
    assign full   = (occ >= cap);
    assign spill  = (occ > {1'b0, hi});
    assign refill = (occ < {1'b0, lo}) && (avail != '0);

    AST_OCC_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= cap); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R2
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R5
    AST_BOTH_KEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> $stable(avail)); // R8
    AST_AVAIL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        avail == AVAIL_W'(occ)); // R11

endmodule

// File: rtl/fpool_ram.sv
// Module fpool_ram
// Shared pointer store: one write port and one registered read port.
// Assumes the write and read addresses never collide in one cycle; the top
// guarantees this because a region keeps two entries in reserve.
module fpool_ram #(
    parameter int DEPTH = 2048,
    parameter int PTR_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [PTR_W-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rdata
);

    logic [PTR_W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/free_ptr_pool.sv
// Module free_ptr_pool
// Multi-queue free pointer pool. It qualifies free and alloc traffic
// against readiness and occupancy, and addresses the shared store at each
// region's base plus the pool's offset. It answers every alloc one cycle
// later, forwarding a same-cycle free into an empty pool. Assumes the sum
// of the programmed sizes stays within DEPTH and NUM_Q is a power of two.
module free_ptr_pool
    import fpool_pkg::*;
#(
    parameter int NUM_Q      = 8,
    parameter int DEPTH      = 2048,
    parameter int PTR_W      = 32,
    parameter int AVAIL_W    = 26,
    parameter int SETTLE_CYC = 10,
    localparam int Q_W    = $clog2(NUM_Q),
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SIZE_W = ADDR_W + 1,
    localparam int WM_W   = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_size_wr,
    input  logic               cfg_mark_wr,
    input  logic [Q_W-1:0]     cfg_q,
    input  logic [SIZE_W-1:0]  cfg_size,
    input  logic [WM_W-1:0]    cfg_hi,
    input  logic [WM_W-1:0]    cfg_lo,
    output logic               ready,
    input  logic               free_vld,
    input  logic [Q_W-1:0]     free_q,
    input  logic [PTR_W-1:0]   free_ptr,
    input  logic               alloc_req,
    input  logic [Q_W-1:0]     alloc_q,
    output logic               alloc_vld,
    output logic [PTR_W-1:0]   alloc_ptr,
    output logic [NUM_Q-1:0]   spill_req,
    output logic [NUM_Q-1:0]   refill_req,
    output logic [NUM_Q-1:0]   ovf_flag,
    input  logic [Q_W-1:0]     avail_q,
    output logic [AVAIL_W-1:0] avail_cnt
);

    logic [NUM_Q-1:0][SIZE_W-1:0]  size_q, base_q, cap_q, rd_off, wr_off;
    logic [NUM_Q-1:0][WM_W-1:0]    hi_q, lo_q;
    logic [NUM_Q-1:0][AVAIL_W-1:0] avail_q_cnt;
    logic [NUM_Q-1:0]              q_empty, q_full;
    logic [NUM_Q-1:0]              push_q, pop_q, drop_q;

    logic             op_en, same_q, a_empty, f_full;
    logic             pop_any, push_any, drop_any, bypass;
    logic [SIZE_W-1:0] waddr_sum, raddr_sum;
    logic [PTR_W-1:0] ram_rdata, byp_ptr;
    rsp_src_e         rsp_src;

    fpool_cfg #(
        .NUM_Q      (NUM_Q),
        .DEPTH      (DEPTH),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .size_wr  (cfg_size_wr),
        .mark_wr  (cfg_mark_wr),
        .cfg_q    (cfg_q),
        .cfg_size (cfg_size),
        .cfg_hi   (cfg_hi),
        .cfg_lo   (cfg_lo),
        .size_o   (size_q),
        .base_o   (base_q),
        .cap_o    (cap_q),
        .hi_o     (hi_q),
        .lo_o     (lo_q),
        .ready_o  (ready)
    );

    // Qualify traffic: ignored while settling or during a size write.
    assign op_en    = ready && !cfg_size_wr;
    assign same_q   = free_vld && alloc_req && (free_q == alloc_q);
    assign a_empty  = q_empty[alloc_q];
    assign f_full   = q_full[free_q];
    assign pop_any  = op_en && alloc_req && !a_empty;
    assign bypass   = op_en && same_q && a_empty;
    assign push_any = op_en && free_vld && (same_q ? !a_empty : !f_full);
    assign drop_any = op_en && free_vld && !same_q && f_full;

    // One bookkeeping instance per pool.
    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        assign push_q[g] = push_any && (free_q == Q_W'(g));
        assign pop_q[g]  = pop_any  && (alloc_q == Q_W'(g));
        assign drop_q[g] = drop_any && (free_q == Q_W'(g));

        fpool_qctl #(
            .SIZE_W  (SIZE_W),
            .AVAIL_W (AVAIL_W)
        ) u_qctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (cfg_size_wr),
            .push   (push_q[g]),
            .pop    (pop_q[g]),
            .drop   (drop_q[g]),
            .size   (size_q[g]),
            .cap    (cap_q[g]),
            .hi     (hi_q[g]),
            .lo     (lo_q[g]),
            .rd_off (rd_off[g]),
            .wr_off (wr_off[g]),
            .avail  (avail_q_cnt[g]),
            .empty  (q_empty[g]),
            .full   (q_full[g]),
            .ovf    (ovf_flag[g]),
            .spill  (spill_req[g]),
            .refill (refill_req[g])
        );
    end

    // Store addresses: region base plus the pool's own offset.
    assign waddr_sum = base_q[free_q]  + wr_off[free_q];
    assign raddr_sum = base_q[alloc_q] + rd_off[alloc_q];

    fpool_ram #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_ram (
        .clk   (clk),
        .we    (push_any),
        .waddr (waddr_sum[ADDR_W-1:0]),
        .wdata (free_ptr),
        .re    (pop_any),
        .raddr (raddr_sum[ADDR_W-1:0]),
        .rdata (ram_rdata)
    );

    // Response pipeline: remember the data source for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_vld <= 1'b0;
            rsp_src   <= RSP_ZERO;
            byp_ptr   <= '0;
        end else begin
            alloc_vld <= alloc_req;
            rsp_src   <= pop_any ? RSP_RAM : (bypass ? RSP_BYPASS : RSP_ZERO);
            if (bypass)
                byp_ptr <= free_ptr;
        end
    end

    // Response data selection.
    always_comb begin
        case (rsp_src)
            RSP_RAM:    alloc_ptr = ram_rdata;
            RSP_BYPASS: alloc_ptr = byp_ptr;
            default:    alloc_ptr = '0;
        endcase
    end

    assign avail_cnt = avail_q_cnt[avail_q];

    AST_NOTREADY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !ready) |=> (alloc_vld && alloc_ptr == '0)); // R3
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !free_vld && q_empty[alloc_q]) |=> (alloc_ptr == '0)); // R5
    AST_RSP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> alloc_vld); // R4

endmodule

// File: tb/free_ptr_pool_bench.sv
module free_ptr_pool_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NQ    = 8;
    localparam int DEP   = 64;
    localparam int PW    = 32;
    localparam int AW    = 26;
    localparam int SZW   = $clog2(DEP) + 1;
    localparam int WMW   = $clog2(DEP);

    typedef struct packed {
        logic        is_alloc;
        logic [2:0]  q;
        logic [15:0] val;
    } vec_t;

    // Free/alloc walk over pools 0,1,2,7 (val = pointer freed or expected).
    localparam vec_t VEC [16] = '{
        '{1'b0, 3'd0, 16'h1001}, '{1'b0, 3'd1, 16'h2001},
        '{1'b0, 3'd2, 16'h3001}, '{1'b0, 3'd0, 16'h1002},
        '{1'b0, 3'd7, 16'h7001}, '{1'b1, 3'd1, 16'h2001},
        '{1'b1, 3'd0, 16'h1001}, '{1'b0, 3'd2, 16'h3002},
        '{1'b1, 3'd2, 16'h3001}, '{1'b1, 3'd7, 16'h7001},
        '{1'b1, 3'd0, 16'h1002}, '{1'b1, 3'd2, 16'h3002},
        '{1'b1, 3'd0, 16'h0000}, '{1'b1, 3'd7, 16'h0000},
        '{1'b1, 3'd1, 16'h0000}, '{1'b1, 3'd2, 16'h0000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_size_wr = 1'b0, cfg_mark_wr = 1'b0;
    logic [2:0]     cfg_q = '0;
    logic [SZW-1:0] cfg_size = '0;
    logic [WMW-1:0] cfg_hi = '0, cfg_lo = '0;
    logic           ready;
    logic           free_vld = 1'b0;
    logic [2:0]     free_q = '0;
    logic [PW-1:0]  free_ptr = '0;
    logic           alloc_req = 1'b0;
    logic [2:0]     alloc_q = '0;
    logic           alloc_vld;
    logic [PW-1:0]  alloc_ptr;
    logic [NQ-1:0]  spill_req, refill_req, ovf_flag;
    logic [2:0]     avail_q = '0;
    logic [AW-1:0]  avail_cnt;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    free_ptr_pool #(
        .NUM_Q(NQ), .DEPTH(DEP), .PTR_W(PW), .AVAIL_W(AW), .SETTLE_CYC(10)
    ) u_free_ptr_pool (
        .clk(clk), .rst_n(rst_n),
        .cfg_size_wr(cfg_size_wr), .cfg_mark_wr(cfg_mark_wr), .cfg_q(cfg_q),
        .cfg_size(cfg_size), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .ready(ready),
        .free_vld(free_vld), .free_q(free_q), .free_ptr(free_ptr),
        .alloc_req(alloc_req), .alloc_q(alloc_q), .alloc_vld(alloc_vld),
        .alloc_ptr(alloc_ptr), .spill_req(spill_req), .refill_req(refill_req),
        .ovf_flag(ovf_flag), .avail_q(avail_q), .avail_cnt(avail_cnt)
    );

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_free(input logic [2:0] q, input logic [PW-1:0] p);
        free_vld = 1'b1; free_q = q; free_ptr = p;
        @(negedge clk);
        free_vld = 1'b0;
    endtask

    task automatic do_alloc(input logic [2:0] q, input logic [PW-1:0] exp,
                            input string tag);
        alloc_req = 1'b1; alloc_q = q;
        @(posedge clk); #1;
        check(alloc_vld === 1'b1 && alloc_ptr === exp, tag, alloc_ptr, exp);
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic do_both(input logic [2:0] q, input logic [PW-1:0] p,
                           input logic [PW-1:0] exp, input string tag);
        free_vld = 1'b1; free_q = q; free_ptr = p;
        alloc_req = 1'b1; alloc_q = q;
        @(posedge clk); #1;
        check(alloc_vld === 1'b1 && alloc_ptr === exp, tag, alloc_ptr, exp);
        @(negedge clk);
        free_vld = 1'b0; alloc_req = 1'b0;
    endtask

    task automatic chk_avail(input logic [2:0] q, input int exp, input string tag);
        avail_q = q; #1;
        check(avail_cnt === AW'(exp), tag, avail_cnt, exp);
    endtask

    // Size write; returns the number of sampled cycles with ready low.
    task automatic set_size(input logic [2:0] q, input int sz, output int lowcnt);
        cfg_size_wr = 1'b1; cfg_q = q; cfg_size = SZW'(sz);
        @(posedge clk); #1;
        cfg_size_wr = 1'b0;
        lowcnt = 0;
        while (!ready && lowcnt < 50) begin
            lowcnt++;
            @(posedge clk); #1;
        end
        @(negedge clk);
    endtask

    task automatic set_marks(input logic [2:0] q, input int hi, input int lo);
        cfg_mark_wr = 1'b1; cfg_q = q;
        cfg_hi = WMW'(hi); cfg_lo = WMW'(lo);
        @(negedge clk);
        cfg_mark_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int lc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(ready === 1'b1, "R1 ready", ready, 1);
        check(spill_req === '0 && refill_req === '0 && ovf_flag === '0,
              "R1 flags", {spill_req, refill_req, ovf_flag}, 0);
        for (int q = 0; q < NQ; q++) chk_avail(3'(q), 0, "R1 avail");
        do_alloc(3'd0, '0, "R1 R5 alloc after reset");

        // R3: settle length after a size write
        set_size(3'd0, 8, lc);
        check(lc == 10, "R3 not-ready cycles", lc, 10);

        // R3: free presented while settling is ignored
        cfg_size_wr = 1'b1; cfg_q = 3'd1; cfg_size = SZW'(5);
        @(negedge clk);
        cfg_size_wr = 1'b0;
        do_free(3'd1, 32'hDEAD);
        while (!ready) @(negedge clk);
        chk_avail(3'd1, 0, "R3 free ignored while settling");
        do_alloc(3'd1, '0, "R3 alloc after ignored free");

        set_size(3'd2, 6, lc);
        set_size(3'd7, 44, lc);

        // R4 R6: vector walk over several pools
        for (int i = 0; i < 16; i++) begin
            if (VEC[i].is_alloc)
                do_alloc(VEC[i].q, PW'(VEC[i].val), "R4 R6 vector alloc");
            else
                do_free(VEC[i].q, PW'(VEC[i].val));
        end

        // R2: pool 1 written with size 5 -> capacity 2; third free dropped
        do_free(3'd1, 32'hB001);
        do_free(3'd1, 32'hB002);
        check(ovf_flag === 8'h00, "R2 no overflow at capacity", ovf_flag, 0);
        do_free(3'd1, 32'hB003);
        check(ovf_flag === 8'h02, "R2 overflow flag", ovf_flag, 2);
        chk_avail(3'd1, 2, "R2 R11 avail at capacity");
        do_alloc(3'd1, 32'hB001, "R2 first kept");
        do_alloc(3'd1, 32'hB002, "R2 second kept");
        do_alloc(3'd1, '0, "R2 R5 dropped pointer absent");
        check(ovf_flag === 8'h02, "R2 overflow sticky", ovf_flag, 2);

        // R7: wrap pool 0 (size 8) repeatedly while holding three pointers
        for (int k = 0; k < 3; k++) do_free(3'd0, 32'hA000 + k);
        for (int k = 0; k < 20; k++) begin
            do_alloc(3'd0, 32'hA000 + k, "R7 wrap order");
            do_free(3'd0, 32'hA000 + k + 3);
        end
        chk_avail(3'd0, 3, "R7 R11 avail after wrap");
        for (int k = 20; k < 23; k++) do_alloc(3'd0, 32'hA000 + k, "R7 drain");

        // R8: same-cycle alloc and free
        do_both(3'd2, 32'hC001, 32'hC001, "R8 bypass on empty");
        chk_avail(3'd2, 0, "R8 count unchanged empty");
        do_free(3'd2, 32'hC002);
        do_free(3'd2, 32'hC003);
        do_both(3'd2, 32'hC004, 32'hC002, "R8 both serviced");
        chk_avail(3'd2, 2, "R8 count unchanged");
        do_alloc(3'd2, 32'hC003, "R8 order kept");
        do_alloc(3'd2, 32'hC004, "R8 free stored");

        // R9 R10: watermarks on pool 7, high 3, low 2
        set_marks(3'd7, 3, 2);
        check(refill_req[7] === 1'b0, "R10 no refill when nothing held", refill_req[7], 0);
        do_free(3'd7, 32'hD001);
        check(refill_req[7] === 1'b1 && spill_req[7] === 1'b0, "R10 refill below low",
              {spill_req[7], refill_req[7]}, 1);
        do_free(3'd7, 32'hD002);
        check(refill_req[7] === 1'b0, "R10 refill off at low", refill_req[7], 0);
        do_free(3'd7, 32'hD003);
        check(spill_req[7] === 1'b0, "R9 no spill at high", spill_req[7], 0);
        do_free(3'd7, 32'hD004);
        check(spill_req[7] === 1'b1, "R9 spill above high", spill_req[7], 1);
        chk_avail(3'd7, 4, "R11 avail pool 7");

        // R3: size write empties every pool
        set_size(3'd0, 8, lc);
        check(lc == 10, "R3 second settle", lc, 10);
        chk_avail(3'd7, 0, "R3 flush avail");
        check(spill_req[7] === 1'b0, "R3 flush spill", spill_req[7], 0);
        do_alloc(3'd7, '0, "R3 flush alloc zero");
        check(ovf_flag === 8'h02, "R2 sticky across resize", ovf_flag, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule